// File: doc/BRIEF.md
# Serial Command and Channel Status Port

This block is the control front end of a 48-channel constant-current LED sink. A host drives a three-wire serial link: a data line, a shift clock and a latch strobe. Bits are collected in a 49-bit shift register. On each latch strobe, the topmost bit and an 8-bit command header decide where the register contents go. They go either to a per-channel enable latch or to a configuration latch. That latch holds a current-range code, one brightness value per colour group and a set of function fields.

The block also holds a 48-bit status word. On the rising edge of the blanking input it samples the per-channel open-load or shorted-load comparator flags, and any channel that is not enabled reads as 0. When the host writes the enable latch, the selected status word is placed in the lower 48 bits of the shift register. The host then clocks it out on the serial output while it shifts in the next frame.

All three host strobes are asynchronous to the system clock. They are synchronized and edge-detected, so every latch action takes exactly one system-clock cycle.

Top module: `strand_ctrl_if`

## Requirements
- R1: On each shift-clock rising edge the data input enters bit 0 and every bit moves one place up. Bit 48 drives `sout` at all times, and `sout` does not change without a shift or latch event.
- R2: On a latch rising edge with bit 48 = 0, bits [47:0] are copied to `chan_en`. Bit 3n enables red channel n, bit 3n+1 enables green channel n, and bit 3n+2 enables blue channel n, for n = 0..15.
- R3: On a latch rising edge with bit 48 = 1, the configuration is written only if bits [47:40] equal 8'h96. Any other header writes nothing, including the pending current-range compare value.
- R4: The configuration fields sit at these positions:
  - current range: [2:0]
  - red brightness: [9:3]
  - green brightness: [16:10]
  - blue brightness: [23:17]
  - status select: [25:24]
  - open threshold: [28:26]
  - short threshold: [30:29]
  - power-save mode: [32:31]

  Bits [39:33] have no effect. Every field except the current range takes effect on every accepted configuration write.
- R5: The current range changes only when an accepted configuration write carries the same value as the previous accepted configuration write. The first write after reset never commits it.
- R6: On an enable-latch write, after `chan_en` takes the old contents, shift bits [47:0] are replaced by the status word when the status select is 01 or 10. With select 00 or 11 nothing is replaced. Configuration writes never load status.
- R7: After status has been loaded, later latch edges load no status until at least one new bit has been shifted in.
- R8: On a blanking rising edge the status word takes the open flags (select 01) or the short flags (select 10), ANDed with `chan_en`. With select 00 or 11 it is unchanged.
- R9: After reset the shift register, `chan_en`, the current range, the brightness values, the status select and the thresholds are 0, and the power-save mode is 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_in | input | 1 | Serial shift clock (asynchronous) |
| sin_in | input | 1 | Serial data in |
| lat_in | input | 1 | Latch strobe (asynchronous) |
| blank_in | input | 1 | Blanking input; rising edge samples status |
| open_flags | input | 48 | Open-load comparator flags per channel |
| short_flags | input | 48 | Shorted-load comparator flags per channel |
| sout | output | 1 | Serial data out (shift bit 48) |
| chan_en | output | 48 | Per-channel enable latch |
| cur_range | output | 3 | Committed current-range code |
| bri_red | output | 7 | Red group brightness |
| bri_grn | output | 7 | Green group brightness |
| bri_blu | output | 7 | Blue group brightness |
| stat_sel | output | 2 | Status select field |
| open_thr | output | 3 | Open-detect threshold code |
| short_thr | output | 2 | Short-detect threshold code |
| psave_mode | output | 2 | Power-save mode field |

## Verification
Most internal state shows up only through the serial path. A wrong status word or a lost reload flag becomes visible once the next enable write has loaded the shift register and the host has clocked out the 49 bits. The bench therefore compares whole read-back frames, not single bits. A corrupted compare value for the current range shows up one accepted configuration write later, when the current range commits or stays where it should not. A header decode fault shows up on the configuration outputs in the cycle just after the synchronized latch edge.

// File: rtl/strand_ctrl_if.sv
module strand_ctrl_if #(
  parameter int          GROUPS   = 16,
  parameter int          SYNC_LEN = 2,
  parameter logic [7:0]  CMD_KEY  = 8'h96
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk_in,
  input  logic                  sin_in,
  input  logic                  lat_in,
  input  logic                  blank_in,
  input  logic [3*GROUPS-1:0]   open_flags,
  input  logic [3*GROUPS-1:0]   short_flags,
  output logic                  sout,
  output logic [3*GROUPS-1:0]   chan_en,
  output logic [2:0]            cur_range,
  output logic [6:0]            bri_red,
  output logic [6:0]            bri_grn,
  output logic [6:0]            bri_blu,
  output logic [1:0]            stat_sel,
  output logic [2:0]            open_thr,
  output logic [1:0]            short_thr,
  output logic [1:0]            psave_mode
);
  localparam int NBIT = 3 * GROUPS;
  localparam int SRW  = NBIT + 1;

  logic [SYNC_LEN:0]   sclk_q, lat_q, blank_q;
  logic [SYNC_LEN-1:0] sin_q;
  logic                shift_ev, lat_ev, blank_ev, sin_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q  <= '0;
      lat_q   <= '0;
      blank_q <= '0;
      sin_q   <= '0;
    end else begin
      sclk_q  <= {sclk_q[SYNC_LEN-1:0], sclk_in};
      lat_q   <= {lat_q[SYNC_LEN-1:0], lat_in};
      blank_q <= {blank_q[SYNC_LEN-1:0], blank_in};
      sin_q   <= {sin_q[SYNC_LEN-2:0], sin_in};
    end

  assign shift_ev = sclk_q[SYNC_LEN-1]  & ~sclk_q[SYNC_LEN];
  assign lat_ev   = lat_q[SYNC_LEN-1]   & ~lat_q[SYNC_LEN];
  assign blank_ev = blank_q[SYNC_LEN-1] & ~blank_q[SYNC_LEN];
  assign sin_s    = sin_q[SYNC_LEN-1];

  logic [SRW-1:0]  sr;
  logic [NBIT-1:0] holder;
  logic [3:0]      mc_pend;
  logic            armed;
  logic            en_wr, cfg_wr, sel_live;

  assign sout     = sr[NBIT];
  assign en_wr    = lat_ev & ~sr[NBIT];
  assign cfg_wr   = lat_ev & sr[NBIT] & (sr[NBIT-1 -: 8] == CMD_KEY);
  assign sel_live = (stat_sel == 2'b01) | (stat_sel == 2'b10);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sr         <= '0;
      chan_en    <= '0;
      armed      <= 1'b1;
      mc_pend    <= 4'b1000;
      cur_range  <= '0;
      bri_red    <= '0;
      bri_grn    <= '0;
      bri_blu    <= '0;
      stat_sel   <= '0;
      open_thr   <= '0;
      short_thr  <= '0;
      psave_mode <= 2'b11;
    end else if (en_wr) begin
      chan_en <= sr[NBIT-1:0];
      if (armed && sel_live) begin
        sr[NBIT-1:0] <= holder;
        armed        <= 1'b0;
      end
    end else if (cfg_wr) begin
      if ({1'b0, sr[2:0]} == mc_pend) cur_range <= sr[2:0];
      mc_pend    <= {1'b0, sr[2:0]};
      bri_red    <= sr[9:3];
      bri_grn    <= sr[16:10];
      bri_blu    <= sr[23:17];
      stat_sel   <= sr[25:24];
      open_thr   <= sr[28:26];
      short_thr  <= sr[30:29];
      psave_mode <= sr[32:31];
    end else if (shift_ev && !lat_ev) begin
      sr    <= {sr[NBIT-1:0], sin_s};
      armed <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      holder <= '0;
    else if (blank_ev && stat_sel == 2'b01)
      holder <= open_flags & chan_en;
    else if (blank_ev && stat_sel == 2'b10)
      holder <= short_flags & chan_en;

  p_sout_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_ev && !lat_ev |=> $stable(sout));

  p_en_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lat_ev && !sr[NBIT] |=> chan_en == $past(sr[NBIT-1:0]));

  p_bad_hdr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lat_ev && sr[NBIT] && sr[NBIT-1 -: 8] != CMD_KEY
      |=> $stable(bri_red) && $stable(stat_sel) && $stable(psave_mode) && $stable(cur_range)
          && $stable(chan_en));

  p_mc_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cur_range != $past(cur_range) |-> $past(cfg_wr));

  p_cfg_noload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> $stable(sr));

  p_no_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lat_ev && !sr[NBIT] && !armed |=> $stable(sr));

  p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    blank_ev |=> (holder & ~$past(chan_en)) == '0);
endmodule

// File: tb/strand_ctrl_if_tb.sv
module strand_ctrl_if_tb;
  logic clk = 0, rst_n = 0;
  logic sclk_in = 0, sin_in = 0, lat_in = 0, blank_in = 0;
  logic [47:0] open_flags = '0, short_flags = '0;
  logic sout;
  logic [47:0] chan_en;
  logic [2:0] cur_range, open_thr;
  logic [6:0] bri_red, bri_grn, bri_blu;
  logic [1:0] stat_sel, short_thr, psave_mode;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  strand_ctrl_if u_dut (.*);

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n); repeat (n) @(negedge clk); endtask
  task automatic put_bit(logic b);
    sin_in = b; tick(3); sclk_in = 1; tick(4); sclk_in = 0; tick(3);
  endtask
  task automatic send(logic [48:0] w);
    for (int i = 48; i >= 0; i--) put_bit(w[i]);
  endtask
  task automatic latch(); lat_in = 1; tick(4); lat_in = 0; tick(4); endtask
  task automatic blank_pulse(); blank_in = 1; tick(4); blank_in = 0; tick(4); endtask
  task automatic readback(output logic [48:0] v);
    for (int i = 48; i >= 0; i--) begin v[i] = sout; put_bit(1'b0); end
  endtask

  function automatic logic [48:0] cfgw(logic [7:0] h, logic [2:0] mc, logic [6:0] r, g, b,
      logic [1:0] sel, logic [2:0] lod, logic [1:0] lsd, logic [1:0] ps);
    return {1'b1, h, 7'h55, ps, lsd, lod, sel, b, g, r, mc};
  endfunction

  // {hdr, mc, red, green, blue, lod, lsd, ps, expected current range}
  localparam logic [41:0] VEC [6] = '{
    {8'h96, 3'd5, 7'h11, 7'h22, 7'h33, 3'd1, 2'd2, 2'd0, 3'd0},
    {8'h96, 3'd5, 7'h7F, 7'h00, 7'h40, 3'd4, 2'd1, 2'd1, 3'd5},
    {8'h95, 3'd3, 7'h01, 7'h02, 7'h03, 3'd7, 2'd3, 2'd3, 3'd5},
    {8'h96, 3'd3, 7'h2A, 7'h15, 7'h6B, 3'd2, 2'd0, 2'd2, 3'd5},
    {8'h96, 3'd7, 7'h05, 7'h7E, 7'h10, 3'd3, 2'd3, 2'd0, 3'd5},
    {8'h96, 3'd7, 7'h00, 7'h01, 7'h7F, 3'd0, 2'd2, 2'd0, 3'd7}
  };

  initial begin
    logic [32:3] exp_cfg;
    logic [48:0] rb, w;
    logic [47:0] pm, om, o2, sm;
    pm = 48'h0F0F_FFFF_00F0; om = 48'h1234_5678_9ABC;
    o2 = 48'hFFFF_FFFF_FFFF; sm = 48'hFEDC_BA98_7654;
    exp_cfg = '0;
    tick(3); rst_n = 1; tick(3);

    // R9 reset state
    chk(sout == 0 && chan_en == 0, "R9 shift/enable", {15'd0, sout, chan_en}, 0);
    chk(cur_range == 0 && psave_mode == 2'b11 && bri_red == 0 && stat_sel == 0,
        "R9 config", {cur_range, psave_mode, bri_red, stat_sel}, {3'd0, 2'b11, 7'd0, 2'd0});

    // R1 shift path round trip
    w = 49'h1_2345_6789_ABCD;
    send(w); readback(rb);
    chk(rb == w, "R1 shift/sout", rb, w);

    // R3 R4 R5 configuration vectors
    foreach (VEC[k]) begin
      logic [41:0] v;
      v = VEC[k];
      send(cfgw(v[41:34], v[33:31], v[30:24], v[23:17], v[16:10], 2'd0, v[9:7], v[6:5], v[4:3]));
      latch();
      if (v[41:34] == 8'h96) exp_cfg = {v[4:3], v[6:5], v[9:7], 2'd0, v[16:10], v[23:17], v[30:24]};
      chk({psave_mode, short_thr, open_thr, stat_sel, bri_blu, bri_grn, bri_red} == exp_cfg,
          "R3/R4 fields", {psave_mode, short_thr, open_thr, stat_sel, bri_blu, bri_grn, bri_red}, exp_cfg);
      chk(cur_range == v[2:0], "R5 current range", cur_range, v[2:0]);
    end

    // R2 single-channel bit position: green channel 2 is bit 7
    send({1'b0, 48'h80}); latch();
    chk(chan_en == 48'h80 && chan_en[3*2+1], "R2 bit map", chan_en, 48'h80);

    // R2 pattern, R6 select 00 loads nothing
    send({1'b0, pm}); latch();
    chk(chan_en == pm, "R2 enable copy", chan_en, pm);
    readback(rb);
    chk(rb == {1'b0, pm}, "R6 sel00 no load", rb, {1'b0, pm});

    // R6 configuration write loads no status (select open)
    w = cfgw(8'h96, 3'd7, 7'h10, 7'h20, 7'h30, 2'b01, 3'd0, 2'd0, 2'd0);
    send(w); latch();
    readback(rb);
    chk(rb == w, "R6 cfg no load", rb, w);
    chk(stat_sel == 2'b01 && cur_range == 3'd7, "R4 select field", {stat_sel, cur_range}, {2'b01, 3'd7});

    // R8 open capture masked, R6 load
    open_flags = om; blank_pulse();
    send({1'b0, pm}); latch();
    readback(rb);
    chk(rb == {1'b0, om & pm}, "R6/R8 open load", rb, {1'b0, om & pm});

    // R7 no reload without shifting
    send({1'b0, pm}); latch();
    open_flags = o2; blank_pulse();
    latch();
    chk(chan_en == (om & pm), "R7 enable from status", chan_en, om & pm);
    readback(rb);
    chk(rb == {1'b0, om & pm}, "R7 no reload", rb, {1'b0, om & pm});

    // R8 short capture
    send(cfgw(8'h96, 3'd7, 7'h10, 7'h20, 7'h30, 2'b10, 3'd0, 2'd0, 2'd0)); latch();
    send({1'b0, pm}); latch();
    readback(rb);
    chk(rb == {1'b0, o2 & pm}, "R8 holder kept", rb, {1'b0, o2 & pm});
    short_flags = sm; blank_pulse();
    send({1'b0, pm}); latch();
    readback(rb);
    chk(rb == {1'b0, sm & pm}, "R8 short load", rb, {1'b0, sm & pm});

    // R6 select 11 loads nothing
    send(cfgw(8'h96, 3'd7, 7'h10, 7'h20, 7'h30, 2'b11, 3'd0, 2'd0, 2'd0)); latch();
    blank_pulse();
    send({1'b0, pm}); latch();
    readback(rb);
    chk(rb == {1'b0, pm}, "R6 sel11 no load", rb, {1'b0, pm});

    // R9 reset again, R5 first write after reset does not commit
    rst_n = 0; tick(2); rst_n = 1; tick(3);
    chk(chan_en == 0 && cur_range == 0 && psave_mode == 2'b11 && sout == 0,
        "R9 re-reset", {chan_en, cur_range, psave_mode}, {48'd0, 3'd0, 2'b11});
    send(cfgw(8'h96, 3'd0, 7'h0, 7'h0, 7'h0, 2'b00, 3'd0, 2'd0, 2'd0)); latch();
    chk(cur_range == 0 && psave_mode == 2'b00, "R5 first write", {cur_range, psave_mode}, 0);
    send(cfgw(8'h96, 3'd6, 7'h0, 7'h0, 7'h0, 2'b00, 3'd0, 2'd0, 2'd0)); latch();
    chk(cur_range == 0, "R5 differing value", cur_range, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule